// File: doc/BRIEF.md
# Snake-Chained Grid Memory Controller

This block manages a small two-dimensional grid of one-bit cells. Variable-length bit tapes, called snakes, are built from them. Each occupied cell stores a data bit, a link to its successor (grow direction plus a "more follows" flag) and a link to its predecessor (shrink direction plus a "has predecessor" flag). A snake is therefore a path of adjacent cells that can be walked in either direction. A small descriptor table, indexed by snake number, records where each snake starts (tail) and where it currently ends (head).

A caller issues one command at a time over a valid/ready handshake. The commands are: create a one-cell snake at a coordinate, grow a snake by one cell in a supplied direction carrying a supplied bit, shrink a snake by one cell, and read back one cell. Each accepted command produces exactly one response pulse with a status. When a grow lands on an occupied cell or leaves the grid, the grow writes nothing and the block raises a crash event that names the snake and its tail and head coordinates. The event stays up until the caller acknowledges it. No command is accepted while it is up, so the grid and table cannot change under an event handler.

Top module: `snake_grid_ctrl`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` and `crash_valid` are 0, no snake is live and every cell reads back as 8'h00.
- R2: Opcodes are 0 = create, 1 = grow, 2 = shrink, 3 = read. Status codes are 0 = done, 1 = crash, 2 = rejected. Directions are 00 = up (y-1), 01 = right (x+1), 10 = down (y+1), 11 = left (x-1). A read returns `rsp_cell` = {occupied, data, grow[1:0], shrink[1:0], next, prev} for the cell at (`cmd_x`,`cmd_y`), with all fields 0 for a free cell.
- R3: Create on a dead snake number at a free cell returns done. It writes the cell occupied with the given bit, grow 00, shrink 00, next 0 and prev 0, and sets the snake's tail and head to that cell. Create on a live snake number returns rejected and changes nothing.
- R4: A successful grow writes the new cell occupied with the given bit, next 0, prev 1, grow 00 and shrink equal to the opposite of the grow direction. The old head gets next 1 and grow equal to the grow direction, and the head coordinate moves to the new cell.
- R5: A grow into an occupied cell, or a create at an occupied cell, returns crash, writes nothing and raises `crash_valid` in the same cycle as the response. `crash_snake` carries the snake number and the crash tail/head outputs carry the table's tail and head (the target cell for a create).
- R6: A grow whose step would leave the 16x16 grid returns crash and writes nothing, exactly like R5.
- R7: While `crash_valid` is 1 its fields hold steady and `cmd_ready` is 0. `crash_ack` clears it on the next clock edge.
- R8: A shrink of a snake of two or more cells frees the head cell, moves the head one step along the freed cell's shrink direction and clears the new head's next flag, all other fields of that cell unchanged.
- R9: A shrink of a one-cell snake frees the cell and makes the snake number dead, so it can be created again.
- R10: Grow or shrink on a dead snake number returns rejected and changes no cell.
- R11: Each accepted command gives exactly one single-cycle `rsp_valid` pulse. `cmd_ready` is 0 from the cycle after acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | Operation code |
| cmd_snake | input | 3 | Snake number |
| cmd_x | input | 4 | X coordinate for create/read |
| cmd_y | input | 4 | Y coordinate for create/read |
| cmd_dir | input | 2 | Grow direction |
| cmd_bit | input | 1 | Data bit for create/grow |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | Response status |
| rsp_cell | output | 8 | Cell contents for a read |
| crash_valid | output | 1 | Crash event pending |
| crash_snake | output | 3 | Snake that crashed |
| crash_tail_x | output | 4 | Tail X of crashed snake |
| crash_tail_y | output | 4 | Tail Y of crashed snake |
| crash_head_x | output | 4 | Head X of crashed snake |
| crash_head_y | output | 4 | Head Y of crashed snake |
| crash_ack | input | 1 | Acknowledge crash event |

## Verification
A snake is created, grown along a right-then-down path and then shrunk cell by cell back to nothing. Every cell is read back after each step, which separates errors in the forward link, the backward link and the opposite-direction encoding. Grows into the snake's own body and off the top and right edges show that occupancy and boundary crashes both block writes and report the right coordinates. Commands on dead and live snake numbers show that rejection leaves the grid intact and that a freed number can be reused.

// File: rtl/snake_pkg.sv
package snake_pkg;
  localparam logic [1:0] OP_CREATE = 2'd0;
  localparam logic [1:0] OP_GROW   = 2'd1;
  localparam logic [1:0] OP_SHRINK = 2'd2;
  localparam logic [1:0] OP_READ   = 2'd3;

  localparam logic [1:0] ST_DONE   = 2'd0;
  localparam logic [1:0] ST_CRASH  = 2'd1;
  localparam logic [1:0] ST_REJECT = 2'd2;

  localparam logic [1:0] DIR_UP    = 2'b00;
  localparam logic [1:0] DIR_RIGHT = 2'b01;
  localparam logic [1:0] DIR_DOWN  = 2'b10;
  localparam logic [1:0] DIR_LEFT  = 2'b11;

  typedef enum logic [1:0] {PH_IDLE, PH_LOOK, PH_COMMIT} phase_t;

  function automatic logic [1:0] dir_back(input logic [1:0] d);
    return d ^ 2'b10;
  endfunction
endpackage

// File: rtl/snake_step.sv
module snake_step #(
  parameter int GRID_W = 16,
  parameter int GRID_H = 16,
  localparam int XW = $clog2(GRID_W),
  localparam int YW = $clog2(GRID_H)
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [1:0]    dir,
  output logic [XW-1:0] nx,
  output logic [YW-1:0] ny,
  output logic          off
);
  import snake_pkg::*;
  always_comb begin
    nx  = x;
    ny  = y;
    off = 1'b0;
    case (dir)
      DIR_UP:    begin ny = y - YW'(1); off = (y == '0); end
      DIR_RIGHT: begin nx = x + XW'(1); off = (x == XW'(GRID_W - 1)); end
      DIR_DOWN:  begin ny = y + YW'(1); off = (y == YW'(GRID_H - 1)); end
      default:   begin nx = x - XW'(1); off = (x == '0); end
    endcase
  end
endmodule

// File: rtl/snake_cell_store.sv
module snake_cell_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          q_occ,
  output logic          q_data,
  output logic [1:0]    q_gdir,
  output logic [1:0]    q_sdir,
  output logic          q_next,
  output logic          q_prev,
  input  logic [AW-1:0] wr_addr,
  input  logic          we_occ,
  input  logic          occ_val,
  input  logic          we_link,
  input  logic          data_val,
  input  logic [1:0]    sdir_val,
  input  logic          prev_val,
  input  logic          we_fwd,
  input  logic [1:0]    gdir_val,
  input  logic          next_val
);
  logic [DEPTH-1:0] occ_r;
  logic             data_m [DEPTH];
  logic [1:0]       gdir_m [DEPTH];
  logic [1:0]       sdir_m [DEPTH];
  logic             next_m [DEPTH];
  logic             prev_m [DEPTH];
  logic             occ_q, data_q, next_q, prev_q;
  logic [1:0]       gdir_q, sdir_q;

  always_ff @(posedge clk) begin
    if (rst) occ_r <= '0;
    else if (we_occ) occ_r[wr_addr] <= occ_val;
  end

  always_ff @(posedge clk) begin
    if (we_link) begin
      data_m[wr_addr] <= data_val;
      sdir_m[wr_addr] <= sdir_val;
      prev_m[wr_addr] <= prev_val;
    end
    if (we_fwd) begin
      gdir_m[wr_addr] <= gdir_val;
      next_m[wr_addr] <= next_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) occ_q <= 1'b0;
    else if (rd_en) occ_q <= occ_r[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      data_q <= data_m[rd_addr];
      gdir_q <= gdir_m[rd_addr];
      sdir_q <= sdir_m[rd_addr];
      next_q <= next_m[rd_addr];
      prev_q <= prev_m[rd_addr];
    end
  end

  assign q_occ  = occ_q;
  assign q_data = occ_q & data_q;
  assign q_gdir = occ_q ? gdir_q : 2'b00;
  assign q_sdir = occ_q ? sdir_q : 2'b00;
  assign q_next = occ_q & next_q;
  assign q_prev = occ_q & prev_q;
endmodule

// File: rtl/snake_desc_table.sv
module snake_desc_table #(
  parameter int NSNAKE = 8,
  parameter int XW = 4,
  parameter int YW = 4,
  localparam int SW = $clog2(NSNAKE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] rd_idx,
  output logic          rd_live,
  output logic [XW-1:0] rd_tx,
  output logic [YW-1:0] rd_ty,
  output logic [XW-1:0] rd_hx,
  output logic [YW-1:0] rd_hy,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  logic          wr_live,
  input  logic [XW-1:0] wr_tx,
  input  logic [YW-1:0] wr_ty,
  input  logic [XW-1:0] wr_hx,
  input  logic [YW-1:0] wr_hy
);
  logic [NSNAKE-1:0] live_r;
  logic [XW-1:0] tx_r [NSNAKE];
  logic [YW-1:0] ty_r [NSNAKE];
  logic [XW-1:0] hx_r [NSNAKE];
  logic [YW-1:0] hy_r [NSNAKE];

  for (genvar i = 0; i < NSNAKE; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) live_r[i] <= 1'b0;
      else if (wr_en && wr_idx == SW'(i)) live_r[i] <= wr_live;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == SW'(i)) begin
        tx_r[i] <= wr_tx;
        ty_r[i] <= wr_ty;
        hx_r[i] <= wr_hx;
        hy_r[i] <= wr_hy;
      end
    end
  end

  assign rd_live = live_r[rd_idx];
  assign rd_tx   = tx_r[rd_idx];
  assign rd_ty   = ty_r[rd_idx];
  assign rd_hx   = hx_r[rd_idx];
  assign rd_hy   = hy_r[rd_idx];
endmodule

// File: rtl/snake_grid_ctrl.sv
module snake_grid_ctrl #(
  parameter int GRID_W = 16,
  parameter int GRID_H = 16,
  parameter int NSNAKE = 8,
  localparam int XW = $clog2(GRID_W),
  localparam int YW = $clog2(GRID_H),
  localparam int SW = $clog2(NSNAKE),
  localparam int DEPTH = GRID_W * GRID_H,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [SW-1:0] cmd_snake,
  input  logic [XW-1:0] cmd_x,
  input  logic [YW-1:0] cmd_y,
  input  logic [1:0]    cmd_dir,
  input  logic          cmd_bit,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [7:0]    rsp_cell,
  output logic          crash_valid,
  output logic [SW-1:0] crash_snake,
  output logic [XW-1:0] crash_tail_x,
  output logic [YW-1:0] crash_tail_y,
  output logic [XW-1:0] crash_head_x,
  output logic [YW-1:0] crash_head_y,
  input  logic          crash_ack
);
  import snake_pkg::*;

  function automatic logic [AW-1:0] cell_addr(input logic [XW-1:0] x, input logic [YW-1:0] y);
    return AW'(y) * AW'(GRID_W) + AW'(x);
  endfunction

  phase_t ph;
  logic accept;
  logic [1:0] op_q, st_q;
  logic [SW-1:0] snk_q;
  logic bit_q, off_q, live_q;
  logic [1:0] dir_q;
  logic [XW-1:0] tx_q, tlx_q, hx_q;
  logic [YW-1:0] ty_q, tly_q, hy_q;

  logic t_live;
  logic [XW-1:0] t_tx, t_hx, a_nx, b_nx, sel_x;
  logic [YW-1:0] t_ty, t_hy, a_ny, b_ny, sel_y;
  logic a_off, b_off;

  logic c_occ, c_data, c_next, c_prev;
  logic [1:0] c_gdir, c_sdir;

  logic [1:0] look_st;
  logic [AW-1:0] wr_addr;
  logic we_occ, occ_val, we_link, we_fwd, next_val, prev_val;
  logic [1:0] sdir_val, gdir_val;
  logic tw_en, tw_live;
  logic [XW-1:0] tw_tx, tw_hx;
  logic [YW-1:0] tw_ty, tw_hy;

  assign cmd_ready = (ph == PH_IDLE) && !crash_valid;
  assign accept    = cmd_valid && cmd_ready;

  snake_desc_table #(.NSNAKE(NSNAKE), .XW(XW), .YW(YW)) i_table (
    .clk(clk), .rst(rst),
    .rd_idx((ph == PH_IDLE) ? cmd_snake : snk_q),
    .rd_live(t_live), .rd_tx(t_tx), .rd_ty(t_ty), .rd_hx(t_hx), .rd_hy(t_hy),
    .wr_en(tw_en), .wr_idx(snk_q), .wr_live(tw_live),
    .wr_tx(tw_tx), .wr_ty(tw_ty), .wr_hx(tw_hx), .wr_hy(tw_hy)
  );

  snake_step #(.GRID_W(GRID_W), .GRID_H(GRID_H)) i_grow_step (
    .x(t_hx), .y(t_hy), .dir(cmd_dir), .nx(a_nx), .ny(a_ny), .off(a_off)
  );

  snake_step #(.GRID_W(GRID_W), .GRID_H(GRID_H)) i_back_step (
    .x(hx_q), .y(hy_q), .dir(c_sdir), .nx(b_nx), .ny(b_ny), .off(b_off)
  );

  always_comb begin
    case (cmd_op)
      OP_GROW:   begin sel_x = a_nx; sel_y = a_ny; end
      OP_SHRINK: begin sel_x = t_hx; sel_y = t_hy; end
      default:   begin sel_x = cmd_x; sel_y = cmd_y; end
    endcase
  end

  snake_cell_store #(.DEPTH(DEPTH)) i_cells (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_addr(cell_addr(sel_x, sel_y)),
    .q_occ(c_occ), .q_data(c_data), .q_gdir(c_gdir), .q_sdir(c_sdir),
    .q_next(c_next), .q_prev(c_prev),
    .wr_addr(wr_addr), .we_occ(we_occ), .occ_val(occ_val),
    .we_link(we_link), .data_val(bit_q), .sdir_val(sdir_val), .prev_val(prev_val),
    .we_fwd(we_fwd), .gdir_val(gdir_val), .next_val(next_val)
  );

  always_comb begin
    case (op_q)
      OP_CREATE: look_st = live_q ? ST_REJECT : (c_occ ? ST_CRASH : ST_DONE);
      OP_GROW:   look_st = !live_q ? ST_REJECT : ((off_q || c_occ) ? ST_CRASH : ST_DONE);
      OP_SHRINK: look_st = live_q ? ST_DONE : ST_REJECT;
      default:   look_st = ST_DONE;
    endcase
  end

  // Cell and table write port control
  always_comb begin
    wr_addr = cell_addr(tx_q, ty_q);
    we_occ = 1'b0; occ_val = 1'b0; we_link = 1'b0; we_fwd = 1'b0;
    sdir_val = 2'b00; prev_val = 1'b0; gdir_val = 2'b00; next_val = 1'b0;
    tw_en = 1'b0; tw_live = 1'b1;
    tw_tx = tlx_q; tw_ty = tly_q; tw_hx = hx_q; tw_hy = hy_q;
    if (ph == PH_LOOK && look_st == ST_DONE) begin
      if (op_q == OP_CREATE || op_q == OP_GROW) begin
        we_occ = 1'b1; occ_val = 1'b1; we_link = 1'b1; we_fwd = 1'b1;
        prev_val = (op_q == OP_GROW);
        sdir_val = (op_q == OP_GROW) ? dir_back(dir_q) : 2'b00;
      end else if (op_q == OP_SHRINK) begin
        we_occ = 1'b1; occ_val = 1'b0;
      end
    end
    if (ph == PH_COMMIT && st_q == ST_DONE) begin
      case (op_q)
        OP_CREATE: begin
          tw_en = 1'b1; tw_tx = tx_q; tw_ty = ty_q; tw_hx = tx_q; tw_hy = ty_q;
        end
        OP_GROW: begin
          wr_addr = cell_addr(hx_q, hy_q);
          we_fwd = 1'b1; gdir_val = dir_q; next_val = 1'b1;
          tw_en = 1'b1; tw_hx = tx_q; tw_hy = ty_q;
        end
        OP_SHRINK: begin
          if (c_prev) begin
            wr_addr = cell_addr(b_nx, b_ny);
            we_fwd = 1'b1; gdir_val = c_gdir_keep; next_val = 1'b0;
            tw_en = 1'b1; tw_hx = b_nx; tw_hy = b_ny;
          end else begin
            tw_en = 1'b1; tw_live = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // Grow direction of the cell that becomes head after a shrink, read in LOOK phase
  logic [1:0] c_gdir_keep;
  logic [AW-1:0] keep_addr;
  assign keep_addr = cell_addr(b_nx, b_ny);
  snake_keep_dir #(.DEPTH(DEPTH)) i_keep (
    .clk(clk), .wr_en(we_fwd), .wr_addr(wr_addr), .wr_dir(gdir_val),
    .rd_addr(keep_addr), .rd_dir(c_gdir_keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;
      rsp_valid <= 1'b0;
      crash_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (crash_valid && crash_ack) crash_valid <= 1'b0;
      case (ph)
        PH_IDLE:   if (accept) ph <= PH_LOOK;
        PH_LOOK:   ph <= PH_COMMIT;
        default: begin
          ph <= PH_IDLE;
          rsp_valid <= 1'b1;
          if (st_q == ST_CRASH) crash_valid <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q <= cmd_op; snk_q <= cmd_snake; bit_q <= cmd_bit; dir_q <= cmd_dir;
      tx_q <= sel_x; ty_q <= sel_y;
      off_q <= (cmd_op == OP_GROW) && a_off;
      live_q <= t_live;
      tlx_q <= t_tx; tly_q <= t_ty; hx_q <= t_hx; hy_q <= t_hy;
    end
    if (ph == PH_LOOK) st_q <= look_st;
    if (ph == PH_COMMIT) begin
      rsp_status <= st_q;
      rsp_cell <= {c_occ, c_data, c_gdir, c_sdir, c_next, c_prev};
      if (st_q == ST_CRASH) begin
        crash_snake <= snk_q;
        if (op_q == OP_CREATE) begin
          crash_tail_x <= tx_q; crash_tail_y <= ty_q;
          crash_head_x <= tx_q; crash_head_y <= ty_q;
        end else begin
          crash_tail_x <= tlx_q; crash_tail_y <= tly_q;
          crash_head_x <= hx_q; crash_head_y <= hy_q;
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = b_off;
endmodule

// File: rtl/snake_grid_chk.sv
module snake_grid_chk #(
  parameter int SW = 3,
  parameter int XW = 4,
  parameter int YW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic          crash_valid,
  input logic [SW-1:0] crash_snake,
  input logic [XW-1:0] crash_head_x,
  input logic [YW-1:0] crash_head_y,
  input logic          crash_ack
);
  // R7
  crash_blocks_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    crash_valid |-> !cmd_ready);
  // R7
  crash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (crash_valid && !crash_ack) |=> (crash_valid && $stable(crash_snake)
      && $stable(crash_head_x) && $stable(crash_head_y)));
  // R5
  crash_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crash_valid) |-> (rsp_valid && rsp_status == 2'd1));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind snake_grid_ctrl snake_grid_chk #(.SW(SW), .XW(XW), .YW(YW)) i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .crash_valid(crash_valid),
  .crash_snake(crash_snake), .crash_head_x(crash_head_x),
  .crash_head_y(crash_head_y), .crash_ack(crash_ack)
);

// File: rtl/snake_keep_dir.sv
module snake_keep_dir #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_dir,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_dir
);
  logic [1:0] mirror_m [DEPTH];
  always_ff @(posedge clk) begin
    if (wr_en) mirror_m[wr_addr] <= wr_dir;
  end
  assign rd_dir = mirror_m[rd_addr];
endmodule

// File: tb/test_snake_grid_ctrl.sv
module test_snake_grid_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_snake = 3'd0;
  logic [3:0] cmd_x = 4'd0, cmd_y = 4'd0;
  logic [1:0] cmd_dir = 2'd0;
  logic cmd_bit = 1'b0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [7:0] rsp_cell;
  logic crash_valid;
  logic [2:0] crash_snake;
  logic [3:0] crash_tail_x, crash_tail_y, crash_head_x, crash_head_y;
  logic crash_ack = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [1:0] got_st;
  logic [7:0] got_cell;

  always #2 clk = ~clk;

  snake_grid_ctrl i_snake_grid_ctrl (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cv(input bit o, input bit d, input logic [1:0] g,
                                    input logic [1:0] s, input bit n, input bit p);
    return {o, d, g, s, n, p};
  endfunction

  task automatic send(input logic [1:0] op, input logic [2:0] sn, input logic [3:0] x,
                      input logic [3:0] y, input logic [1:0] d, input logic b);
    @(negedge clk);
    cmd_op = op; cmd_snake = sn; cmd_x = x; cmd_y = y; cmd_dir = d; cmd_bit = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R11 busy", cmd_ready, 0);
    while (!rsp_valid) @(negedge clk);
    got_st = rsp_status; got_cell = rsp_cell;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 pulse", rsp_valid, 0);
  endtask

  task automatic rd_cell(input logic [3:0] x, input logic [3:0] y, input logic [7:0] exp, input string tag);
    send(2'd3, 3'd0, x, y, 2'd0, 1'b0);
    check(got_cell == exp, tag, got_cell, exp);
  endtask

  task automatic ack_crash;
    @(negedge clk); crash_ack = 1'b1;
    @(negedge clk); crash_ack = 1'b0;
    check(crash_valid == 1'b0, "R7 ack clears", crash_valid, 0);
    check(cmd_ready == 1'b1, "R7 ready after ack", cmd_ready, 1);
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
    check(crash_valid == 1'b0, "R1 crash", crash_valid, 0);
    rd_cell(4'd5, 4'd5, 8'h00, "R1 free cell");
    send(2'd1, 3'd3, 4'd0, 4'd0, 2'd1, 1'b1);
    check(got_st == 2'd2, "R1 no live snake", got_st, 2);
  endtask

  task automatic t_create_grow;
    send(2'd0, 3'd0, 4'd5, 4'd5, 2'd0, 1'b1);
    check(got_st == 2'd0, "R3 create", got_st, 0);
    rd_cell(4'd5, 4'd5, cv(1, 1, 2'b00, 2'b00, 0, 0), "R3 cell");
    send(2'd1, 3'd0, 4'd0, 4'd0, 2'b01, 1'b0);
    check(got_st == 2'd0, "R4 grow right", got_st, 0);
    rd_cell(4'd5, 4'd5, cv(1, 1, 2'b01, 2'b00, 1, 0), "R4 old head");
    rd_cell(4'd6, 4'd5, cv(1, 0, 2'b00, 2'b11, 0, 1), "R2 R4 new cell left back");
    send(2'd1, 3'd0, 4'd0, 4'd0, 2'b10, 1'b1);
    check(got_st == 2'd0, "R4 grow down", got_st, 0);
    rd_cell(4'd6, 4'd6, cv(1, 1, 2'b00, 2'b00, 0, 1), "R2 R4 down cell");
    rd_cell(4'd6, 4'd5, cv(1, 0, 2'b10, 2'b11, 1, 1), "R4 mid cell");
    send(2'd0, 3'd0, 4'd9, 4'd9, 2'd0, 1'b0);
    check(got_st == 2'd2, "R3 create on live", got_st, 2);
    rd_cell(4'd9, 4'd9, 8'h00, "R3 reject no write");
  endtask

  task automatic t_crash_body;
    send(2'd1, 3'd0, 4'd0, 4'd0, 2'b00, 1'b0);
    check(got_st == 2'd1, "R5 status", got_st, 1);
    check(crash_valid == 1'b1, "R5 event", crash_valid, 1);
    check(crash_snake == 3'd0, "R5 snake", crash_snake, 0);
    check({crash_tail_x, crash_tail_y} == 8'h55, "R5 tail", {crash_tail_x, crash_tail_y}, 8'h55);
    check({crash_head_x, crash_head_y} == 8'h66, "R5 head", {crash_head_x, crash_head_y}, 8'h66);
    repeat (4) @(negedge clk);
    check(crash_valid == 1'b1, "R7 held", crash_valid, 1);
    check(cmd_ready == 1'b0, "R7 blocked", cmd_ready, 0);
    check(crash_snake == 3'd0, "R7 stable", crash_snake, 0);
    ack_crash();
    rd_cell(4'd6, 4'd5, cv(1, 0, 2'b10, 2'b11, 1, 1), "R5 target untouched");
    rd_cell(4'd6, 4'd6, cv(1, 1, 2'b00, 2'b00, 0, 1), "R5 head untouched");
  endtask

  task automatic t_crash_edge;
    send(2'd0, 3'd1, 4'd15, 4'd0, 2'd0, 1'b0);
    check(got_st == 2'd0, "R6 setup", got_st, 0);
    send(2'd1, 3'd1, 4'd0, 4'd0, 2'b01, 1'b1);
    check(got_st == 2'd1, "R6 right edge", got_st, 1);
    check(crash_snake == 3'd1, "R6 snake", crash_snake, 1);
    check({crash_head_x, crash_head_y} == 8'hF0, "R6 head", {crash_head_x, crash_head_y}, 8'hF0);
    ack_crash();
    send(2'd1, 3'd1, 4'd0, 4'd0, 2'b00, 1'b1);
    check(got_st == 2'd1, "R6 top edge", got_st, 1);
    ack_crash();
    rd_cell(4'd15, 4'd0, cv(1, 0, 2'b00, 2'b00, 0, 0), "R6 no write");
    rd_cell(4'd0, 4'd0, 8'h00, "R6 no wrap write");
  endtask

  task automatic t_shrink;
    send(2'd2, 3'd0, 4'd0, 4'd0, 2'd0, 1'b0);
    check(got_st == 2'd0, "R8 shrink", got_st, 0);
    rd_cell(4'd6, 4'd6, 8'h00, "R8 freed");
    rd_cell(4'd6, 4'd5, cv(1, 0, 2'b10, 2'b11, 0, 1), "R8 new head");
    send(2'd2, 3'd0, 4'd0, 4'd0, 2'd0, 1'b0);
    rd_cell(4'd6, 4'd5, 8'h00, "R8 freed 2");
    rd_cell(4'd5, 4'd5, cv(1, 1, 2'b01, 2'b00, 0, 0), "R8 tail head");
    send(2'd2, 3'd0, 4'd0, 4'd0, 2'd0, 1'b0);
    check(got_st == 2'd0, "R9 last shrink", got_st, 0);
    rd_cell(4'd5, 4'd5, 8'h00, "R9 freed");
    send(2'd1, 3'd0, 4'd0, 4'd0, 2'b00, 1'b1);
    check(got_st == 2'd2, "R10 grow dead", got_st, 2);
    rd_cell(4'd5, 4'd4, 8'h00, "R10 no write");
    send(2'd2, 3'd7, 4'd0, 4'd0, 2'd0, 1'b0);
    check(got_st == 2'd2, "R10 shrink dead", got_st, 2);
    rd_cell(4'd15, 4'd0, cv(1, 0, 2'b00, 2'b00, 0, 0), "R10 other intact");
    send(2'd0, 3'd0, 4'd2, 4'd3, 2'd0, 1'b1);
    check(got_st == 2'd0, "R9 reuse", got_st, 0);
    send(2'd0, 3'd2, 4'd15, 4'd0, 2'd0, 1'b0);
    check(got_st == 2'd1, "R5 create occupied", got_st, 1);
    check({crash_head_x, crash_head_y} == 8'hF0, "R5 create coord", {crash_head_x, crash_head_y}, 8'hF0);
    ack_crash();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_create_grow();
    t_crash_body();
    t_crash_edge();
    t_shrink();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule